// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo audio stream carried on three external lines (a bit clock, a word clock that marks the channel, and a serial data line) and turns it into parallel 24-bit left and right samples. All three lines are asynchronous to the block's own system clock. They are brought into that clock domain through a short synchronizer chain and then oversampled. A rising edge of the synchronized bit clock marks each serial bit.

A 3-bit format select chooses how the data is placed inside each channel slot. In I2S the word starts one bit after the word-clock change. In left-justified mode it starts on the first bit after the change. In the right-justified modes, 16, 18, 20 or 24 bits end exactly at the next word-clock change. Shorter words are sign-extended to 24 bits.

A completed left/right pair is offered on a valid/ready output port. `m_valid` rises one system clock after the bit that closes the right slot has been seen. It stays high, with `m_left` and `m_right` held, until the consumer asserts `m_ready`. Audio cannot be stalled, so a new pair that completes while the old one is still waiting replaces it, and the older pair is lost. With `m_ready` tied high, `m_valid` is a single-cycle strobe once per frame.

Top module: `sar_rx_top`

## Requirements
- R1: The format select decodes as follows: 010 selects left-justified; 011, 100, 101 and 110 select right-justified with 24, 20, 16 and 18 data bits; 000, 001 and 111 all select I2S.
- R2: In I2S, the left channel is the slot with word clock low. The sample MSB is the second bit captured after the word-clock change. The next 23 bits complete the word, and later bits in the slot have no effect.
- R3: In left-justified mode, the left channel is the slot with word clock high. The MSB is the first bit captured after the word-clock change, and bits after the 24th have no effect.
- R4: In right-justified modes, the left channel is the slot with word clock high. The word is the last N bits captured before the next word-clock change, with the LSB last, and any earlier bits in the slot have no effect.
- R5: Right-justified words shorter than 24 bits appear on the outputs sign-extended from their MSB; two's-complement values keep their sign.
- R6: Each left slot followed by a right slot produces exactly one output pair. `m_valid` rises on the system clock after the right slot has been closed by the next word-clock change, and `m_left`/`m_right` carry the two words.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and the data stays stable unless a newer pair completes, which replaces it. A cycle with both `m_valid` and `m_ready` high consumes the pair.
- R8: Reset clears `m_valid`, `m_left` and `m_right` to zero. A slot whose start was not seen after reset never contributes to an output pair.
- R9: Data is taken only at rising edges of the bit clock; changes on the data line while the bit clock is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| wclk_i | input | 1 | Word clock, its level selects the channel slot |
| sdat_i | input | 1 | Serial two's-complement data, MSB first |
| fmt_i | input | 3 | Data format select, held static while running |
| m_ready | input | 1 | Consumer accepts the offered pair |
| m_valid | output | 1 | A left/right pair is offered |
| m_left | output | 24 | Left sample, sign-extended |
| m_right | output | 24 | Right sample, sign-extended |

## Verification
The bench fills every bit a format ignores with random values: the I2S lead-in bit, the padding after 24 bits, the leading bits of right-justified slots, and junk driven on the data line during bit-clock high. A design off by one bit position, sampling on the wrong edge, or reading padding as data would then produce scrambled words. Extreme values (most negative, most positive, all ones) in each word length expose a wrong sign-extension point. Each run starts with a partial slot and ends with a lone closing word-clock change. A receiver that trusted the first slot would emit an extra pair, and one that did not use the closing change would lose the last pair. A held-off consumer with two frames arriving checks both the hold and the replacement of the older pair.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ALIGN_I2S   = 2'd0,
    ALIGN_LEFT  = 2'd1,
    ALIGN_RIGHT = 2'd2
  } align_e;

  typedef struct packed {
    align_e     align;
    logic [5:0] rj_bits;
  } fmt_cfg_t;

  // R1: format select decode
  function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
    fmt_cfg_t c;
    c.align   = ALIGN_I2S;
    c.rj_bits = 6'd24;
    case (code)
      3'b010: c.align = ALIGN_LEFT;
      3'b011: begin c.align = ALIGN_RIGHT; c.rj_bits = 6'd24; end
      3'b100: begin c.align = ALIGN_RIGHT; c.rj_bits = 6'd20; end
      3'b101: begin c.align = ALIGN_RIGHT; c.rj_bits = 6'd16; end
      3'b110: begin c.align = ALIGN_RIGHT; c.rj_bits = 6'd18; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sar_slot.sv
module sar_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic wclk,
  input  logic sdat,
  output logic bit_stb,
  output logic bit_val,
  output logic slot_edge,
  output logic ended_lvl
);
  logic bclk_q;
  logic wclk_q;
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      wclk_q <= 1'b0;
      primed <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (bit_stb) begin
        wclk_q <= wclk;
        primed <= 1'b1;
      end
    end
  end

  // R9: one strobe per rising bit-clock edge
  assign bit_stb   = bclk & ~bclk_q;
  assign bit_val   = sdat;
  assign slot_edge = bit_stb & primed & (wclk != wclk_q);
  assign ended_lvl = wclk_q;
endmodule

// File: rtl/sar_deser.sv
module sar_deser
  import sar_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_code,
  input  logic                bit_stb,
  input  logic                bit_val,
  input  logic                slot_edge,
  input  logic                ended_lvl,
  output logic                frame_done,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam int CNT_W = $clog2(SLOT_W + 1);
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_W);
  localparam logic [CNT_W-1:0] WORD_N  = CNT_W'(SAMPLE_W);

  fmt_cfg_t            cfg;
  logic [CNT_W-1:0]    cnt, idx, off;
  logic                take, ended_left, in_slot, have_left, sgn;
  logic [SAMPLE_W-1:0] acc, sr, left_hold, rj_word, word;
  logic [5:0]          msb_pos;

  assign cfg = decode_fmt(fmt_code);
  // R2: I2S skips one bit; R3: left-justified starts at once
  assign off  = (cfg.align == ALIGN_I2S) ? CNT_W'(1) : '0;
  assign idx  = slot_edge ? '0 : cnt;
  assign take = (idx >= off) && (idx < off + WORD_N);

  // R4/R5: last N bits of the slot, sign-extended
  assign msb_pos = cfg.rj_bits - 6'd1;
  assign sgn     = sr[msb_pos[IDX_W-1:0]];
  always_comb begin
    rj_word = '0;
    for (int i = 0; i < SAMPLE_W; i++)
      rj_word[i] = (i < int'(cfg.rj_bits)) ? sr[i] : sgn;
  end

  assign word       = (cfg.align == ALIGN_RIGHT) ? rj_word : acc;
  assign ended_left = (cfg.align == ALIGN_I2S) ? ~ended_lvl : ended_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      acc        <= '0;
      sr         <= '0;
      left_hold  <= '0;
      left_o     <= '0;
      right_o    <= '0;
      in_slot    <= 1'b0;
      have_left  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (bit_stb) begin
        sr  <= {sr[SAMPLE_W-2:0], bit_val};
        cnt <= (idx == CNT_MAX) ? idx : idx + 1'b1;
        if (slot_edge)
          acc <= take ? {{(SAMPLE_W-1){1'b0}}, bit_val} : '0;
        else if (take)
          acc <= {acc[SAMPLE_W-2:0], bit_val};
      end
      if (slot_edge) begin
        in_slot <= 1'b1;
        // R8: the slot in progress at reset release is never used
        if (in_slot) begin
          if (ended_left) begin
            left_hold <= word;
            have_left <= 1'b1;
          end else if (have_left) begin
            left_o     <= left_hold;
            right_o    <= word;
            frame_done <= 1'b1;
            have_left  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_rx_top.sv
module sar_rx_top #(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                sdat_i,
  input  logic [2:0]          fmt_i,
  input  logic                m_ready,
  output logic                m_valid,
  output logic [SAMPLE_W-1:0] m_left,
  output logic [SAMPLE_W-1:0] m_right
);
  logic [2:0]          lines_s;
  logic                bit_stb, bit_val, slot_edge, ended_lvl;
  logic                frame_done;
  logic [SAMPLE_W-1:0] left_w, right_w;

  sar_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bclk_i, wclk_i, sdat_i}),
    .q     (lines_s)
  );

  sar_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk      (lines_s[2]),
    .wclk      (lines_s[1]),
    .sdat      (lines_s[0]),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .slot_edge (slot_edge),
    .ended_lvl (ended_lvl)
  );

  sar_deser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_code   (fmt_i),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .slot_edge  (slot_edge),
    .ended_lvl  (ended_lvl),
    .frame_done (frame_done),
    .left_o     (left_w),
    .right_o    (right_w)
  );

  // R6/R7: output register, newest pair wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_left  <= '0;
      m_right <= '0;
    end else if (frame_done) begin
      m_valid <= 1'b1;
      m_left  <= left_w;
      m_right <= right_w;
    end else if (m_valid && m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          fmt_i,
  input logic                m_ready,
  input logic                m_valid,
  input logic [SAMPLE_W-1:0] m_left,
  input logic [SAMPLE_W-1:0] m_right,
  input logic                frame_done
);
  a_r6_valid_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> m_valid);

  a_r6_single_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid);

  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !frame_done) |=> ($stable(m_left) && $stable(m_right)));

  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(frame_done));

  a_r5_rj16_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && fmt_i == 3'b101) |=>
      ((m_right[SAMPLE_W-1:15] == '0) || (m_right[SAMPLE_W-1:15] == '1)));
endmodule

bind sar_rx_top sar_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_i      (fmt_i),
  .m_ready    (m_ready),
  .m_valid    (m_valid),
  .m_left     (m_left),
  .m_right    (m_right),
  .frame_done (frame_done)
);

// File: tb/sim_sar_rx_top.sv
module sim_sar_rx_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sdat = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic        m_ready = 1'b1;
  logic        m_valid;
  logic [23:0] m_left, m_right;

  int          checks = 0;
  int          failures = 0;
  bit          mon_en = 1'b0;
  string       tag = "";
  logic [47:0] expq [$];

  always #(CLK_P/2) clk = ~clk;

  sar_rx_top u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdat_i(sdat),
    .fmt_i(fmt), .m_ready(m_ready), .m_valid(m_valid),
    .m_left(m_left), .m_right(m_right)
  );

  function automatic bit is_justified(input logic [2:0] f);
    return (f >= 3'b010) && (f <= 3'b110);
  endfunction

  function automatic int rj_width(input logic [2:0] f);
    case (f)
      3'b011: return 24;
      3'b100: return 20;
      3'b101: return 16;
      3'b110: return 18;
      default: return 0;
    endcase
  endfunction

  function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] w);
    int n = rj_width(f);
    logic [23:0] e = w;
    if (n != 0)
      for (int i = 0; i < 24; i++) e[i] = (i < n) ? w[i] : w[n-1];
    return e;
  endfunction

  // bit 31 is sent first
  function automatic logic [31:0] make_slot(input logic [2:0] f, input logic [23:0] w);
    logic [31:0] p = $urandom();
    case (f)
      3'b010: p[31:8]  = w;
      3'b011: p[23:0]  = w;
      3'b100: p[19:0]  = w[19:0];
      3'b101: p[15:0]  = w[15:0];
      3'b110: p[17:0]  = w[17:0];
      default: p[30:7] = w;
    endcase
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_en && m_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R6 R8", "unexpected pair", {m_left, m_right}, 48'h0);
      end else begin
        logic [47:0] e;
        e = expq.pop_front();
        chk({m_left, m_right} == e, tag, "pair", {m_left, m_right}, e);
      end
    end
  end

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk); bclk = 1'b0; wclk = w; sdat = d;
    repeat (HALF-1) @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    repeat (2) @(negedge clk);
    sdat = 1'($urandom());              // R9: junk while bit clock is high
    repeat (HALF-2) @(negedge clk);
  endtask

  task automatic send_slot(input logic lvl, input logic [31:0] p);
    for (int i = 31; i >= 0; i--) send_bit(lvl, p[i]);
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input bit push);
    logic lvl = is_justified(fmt);
    if (push) expq.push_back({expect_word(fmt, l), expect_word(fmt, r)});
    send_slot(lvl, make_slot(fmt, l));
    send_slot(~lvl, make_slot(fmt, r));
  endtask

  task automatic do_reset(input logic [2:0] f);
    @(negedge clk); rst_n = 1'b0; bclk = 1'b0; fmt = f;
    repeat (4) @(negedge clk);
    chk(!m_valid && m_left == 24'h0 && m_right == 24'h0, "R8", "reset state",
        {23'h0, m_valid, m_left}, 48'h0);
    expq.delete();
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic lead_in();
    for (int i = 0; i < 7; i++) send_bit(~is_justified(fmt), 1'($urandom()));
  endtask

  task automatic close_out();
    for (int i = 0; i < 4; i++) send_bit(is_justified(fmt), 1'($urandom()));
    repeat (20) @(negedge clk);
  endtask

  task automatic run_phase(input logic [2:0] f, input int nrand, input string t);
    int n;
    do_reset(f);
    tag = t;
    mon_en = 1'b1;
    n = rj_width(f);
    if (n == 0) n = 24;
    lead_in();
    send_frame(24'h1 << (n-1), (24'h1 << (n-1)) - 24'h1, 1'b1);
    send_frame(24'hFFFFFF, 24'h000000, 1'b1);
    for (int k = 0; k < nrand; k++) send_frame(24'($urandom()), 24'($urandom()), 1'b1);
    close_out();
    chk(expq.size() == 0, "R6", "all pairs delivered", 48'(expq.size()), 48'h0);
  endtask

  initial begin
    logic [23:0] a_l, a_r, b_l, b_r;
    void'($urandom(32'd20240611));
    run_phase(3'b000, 10, "R1 R2 R9");
    run_phase(3'b001, 2,  "R1 R2");
    run_phase(3'b111, 2,  "R1 R2");
    run_phase(3'b010, 10, "R1 R3 R9");
    run_phase(3'b011, 8,  "R1 R4");
    run_phase(3'b100, 8,  "R1 R4 R5");
    run_phase(3'b101, 8,  "R1 R4 R5");
    run_phase(3'b110, 8,  "R1 R4 R5");

    // R7: consumer held off while two pairs complete
    do_reset(3'b010);
    mon_en = 1'b0;
    m_ready = 1'b0;
    lead_in();
    a_l = 24'($urandom()); a_r = 24'($urandom());
    b_l = 24'($urandom()); b_r = 24'($urandom());
    send_frame(a_l, a_r, 1'b0);
    send_frame(b_l, b_r, 1'b0);
    close_out();
    chk(m_valid && m_left == b_l && m_right == b_r, "R7", "newest pair held",
        {m_left, m_right}, {b_l, b_r});
    repeat (50) @(negedge clk);
    chk(m_valid && m_left == b_l && m_right == b_r, "R7", "pair stable under stall",
        {m_left, m_right}, {b_l, b_r});
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!m_valid, "R7", "pair consumed", {47'h0, m_valid}, 48'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule